// File: doc/BRIEF.md
# Fault Current-Limit Gain Unit

This unit runs once per phase in the control loop of a grid-forming inverter. It turns the RMS value of the inductor current reference into two scaling gains. The voltage gain `k1` lowers the voltage set-point as the current rises above rating. The current gain `k2` pulls the current reference back to the rated value, so the phase keeps driving a bounded sinusoidal current into a short circuit.

`k1` falls along a straight line. It equals one at the rated current `I` and reaches zero at `(1+K)·I`, where `K` is a speed factor. When the computed `k1` drops, it is applied at once, which gives a fast attack on fault onset. When it rises, after the fault clears, it moves up through a first-order step with coefficient close to 0.01. The voltage therefore comes back smoothly and does not overshoot.

Each control tick starts a new evaluation. A bit-serial divider produces the quotients, and both gains land together a fixed number of clock cycles after the tick.

Top module: `sc_gain_limiter`

## Requirements
- R1: During and after reset, before any evaluation completes, `k1_o` and `k2_o` both read 32768 (1.0 in unsigned Q1.15).
- R2: The speed factor `kspd_i` is unsigned Q4.12, and the code computes KI = floor(kspd·I/4096) and HI = I + KI. The raw `k1` is 32768 whenever `irms_i` ≤ `irated_i`.
- R3: For I < irms < HI, the raw `k1` is floor((HI − irms)·32768 / KI).
- R4: For irms ≥ HI, the raw `k1` is 0. With KI = 0, any irms above I therefore gives 0.
- R5: `k2_o` is 32768 when irms < I or irms = 0. Otherwise it is floor(I·32768 / irms).
- R6: If the raw `k1` is not greater than the `k1_o` currently applied, the new `k1_o` equals the raw value.
- R7: If the raw `k1` exceeds the applied value P, the new `k1_o` is P + max(1, floor((raw − P)·655 / 65536)).
- R8: Both outputs change only on the 18th rising edge after the edge that accepted a tick, and both hold their values at every other edge.
- R9: A tick is accepted only at an edge that is at least 19 edges after the previously accepted tick. A tick at an earlier edge is ignored, and its inputs have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Control-rate strobe that starts an evaluation |
| irms_i | input | 16 | RMS of the inductor current reference, unsigned |
| irated_i | input | 16 | Rated current I, same scale as `irms_i` |
| kspd_i | input | 16 | Speed factor K, unsigned Q4.12 |
| k1_o | output | 16 | Applied voltage gain, unsigned Q1.15 |
| k2_o | output | 16 | Current clamp gain, unsigned Q1.15 |

## Verification
A new tick and the landing of the previous result can fall on the same clock edge. The result is written on the 18th edge after acceptance, and an early tick can arrive at that same edge. The bench places ticks at 18 edges after an accepted one, which must be ignored, and at 19 edges, which must be accepted. A behavioural model that knows only the acceptance rule and the latency judges every cycle, so a dropped or doubled update shows up at once. The release step and the instant attack also meet in one update: a ramp of `k1` is interrupted by a new fault, and the model checks that this single update replaces the filtered rise with the lower raw value.

// File: rtl/sc_gain_pkg.sv
package sc_gain_pkg;
  localparam int GW = 16;
  localparam int GFB = GW - 1;
  typedef logic [GW-1:0] gain_t;
  localparam gain_t GAIN_ONE = gain_t'(1) << GFB;

  typedef enum logic [1:0] {
    K1_ONE  = 2'd0,
    K1_ZERO = 2'd1,
    K1_DIV  = 2'd2
  } k1_mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PREP = 2'd1,
    SEQ_WAIT = 2'd2
  } seq_e;
endpackage

// File: rtl/sc_gain_div.sv
// Restoring divider: quo = floor(num * 2^(QW-1) / den), requires num <= den.
module sc_gain_div #(
  parameter int W  = 20,
  parameter int QW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [W-1:0]  num_i,
  input  logic [W-1:0]  den_i,
  output logic [QW-1:0] quo_o,
  output logic          done_o
);
  localparam int CNTW = $clog2(QW);

  logic [W:0]      rem_q;
  logic [W-1:0]    den_q;
  logic [QW-1:0]   quo_q;
  logic [CNTW-1:0] cnt_q;
  logic            busy_q;
  logic            done_q;
  logic            ge_w;
  logic [W:0]      diff_w;

  assign ge_w   = rem_q >= {1'b0, den_q};
  assign diff_w = ge_w ? (rem_q - {1'b0, den_q}) : rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q  <= {1'b0, num_i};
        den_q  <= den_i;
        quo_q  <= '0;
        cnt_q  <= CNTW'(QW - 1);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        quo_q <= {quo_q[QW-2:0], ge_w};
        rem_q <= diff_w << 1;
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign quo_o  = quo_q;
  assign done_o = done_q;
endmodule

// File: rtl/sc_gain_region.sv
// Classifies the current into gain regions and forms divider operands.
module sc_gain_region
  import sc_gain_pkg::*;
#(
  parameter int CW = 16,
  parameter int KW = 16,
  parameter int KF = 12,
  localparam int DW = CW + KW - KF
) (
  input  logic [CW-1:0] irms_i,
  input  logic [CW-1:0] irated_i,
  input  logic [KW-1:0] kspd_i,
  output k1_mode_e      k1_mode_o,
  output logic          k2_div_o,
  output logic [DW-1:0] k1_num_o,
  output logic [DW-1:0] k1_den_o,
  output logic [DW-1:0] k2_num_o,
  output logic [DW-1:0] k2_den_o
);
  logic [CW+KW-1:0] prod_w;
  logic [DW-1:0]    ki_w;
  logic [DW:0]      hi_w;
  logic [DW:0]      irms_x;

  assign prod_w = CW'(irated_i) * KW'(kspd_i);
  assign ki_w   = DW'(prod_w >> KF);
  assign hi_w   = (DW+1)'(irated_i) + (DW+1)'(ki_w);
  assign irms_x = (DW+1)'(irms_i);

  always_comb begin
    if (irms_i <= irated_i)  k1_mode_o = K1_ONE;
    else if (irms_x >= hi_w) k1_mode_o = K1_ZERO;
    else                     k1_mode_o = K1_DIV;
  end

  assign k2_div_o = (irms_i >= irated_i) && (irms_i != '0);
  assign k1_num_o = DW'(hi_w - irms_x);
  assign k1_den_o = ki_w;
  assign k2_num_o = DW'(irated_i);
  assign k2_den_o = DW'(irms_i);
endmodule

// File: rtl/sc_gain_release.sv
// Applied k1: immediate on fall, first-order step on rise.
module sc_gain_release
  import sc_gain_pkg::*;
#(
  parameter int ALPHA_Q16 = 655,
  localparam int AFB = 16
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  upd_i,
  input  gain_t raw_i,
  output gain_t k1_o
);
  localparam logic [AFB-1:0] ALPHA_V = AFB'(ALPHA_Q16);

  gain_t k1_q;
  gain_t delta_w;
  gain_t step_w;
  gain_t scaled_w;

  assign delta_w  = raw_i - k1_q;
  assign scaled_w = GW'(((GW+AFB)'(delta_w) * (GW+AFB)'(ALPHA_V)) >> AFB);
  assign step_w   = (scaled_w == '0) ? gain_t'(1) : scaled_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k1_q <= GAIN_ONE;
    end else if (upd_i) begin
      if (raw_i > k1_q) k1_q <= k1_q + step_w;
      else              k1_q <= raw_i;
    end
  end

  assign k1_o = k1_q;
endmodule

// File: rtl/sc_gain_limiter.sv
module sc_gain_limiter
  import sc_gain_pkg::*;
#(
  parameter int CW        = 16,
  parameter int KW        = 16,
  parameter int KF        = 12,
  parameter int ALPHA_Q16 = 655
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [CW-1:0] irms_i,
  input  logic [CW-1:0] irated_i,
  input  logic [KW-1:0] kspd_i,
  output logic [GW-1:0] k1_o,
  output logic [GW-1:0] k2_o
);
  localparam int DW = CW + KW - KF;
  localparam int ND = 2;

  seq_e          seq_q;
  logic [CW-1:0] irms_q;
  logic [CW-1:0] irated_q;
  logic [KW-1:0] kspd_q;
  gain_t         k2_q;

  k1_mode_e      k1_mode_w;
  logic          k2_div_w;
  logic [DW-1:0] num_w [ND];
  logic [DW-1:0] den_w [ND];
  gain_t         quo_w [ND];
  logic [ND-1:0] done_w;
  logic          start_w;
  logic          upd_w;
  gain_t         k1_raw_w;
  gain_t         k2_new_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q    <= SEQ_IDLE;
      irms_q   <= '0;
      irated_q <= '0;
      kspd_q   <= '0;
    end else begin
      unique case (seq_q)
        SEQ_IDLE: if (tick_i) begin
          irms_q   <= irms_i;
          irated_q <= irated_i;
          kspd_q   <= kspd_i;
          seq_q    <= SEQ_PREP;
        end
        SEQ_PREP: seq_q <= SEQ_WAIT;
        SEQ_WAIT: if (upd_w) seq_q <= SEQ_IDLE;
        default:  seq_q <= SEQ_IDLE;
      endcase
    end
  end

  assign start_w = (seq_q == SEQ_PREP);
  assign upd_w   = (seq_q == SEQ_WAIT) && (&done_w);

  sc_gain_region #(.CW(CW), .KW(KW), .KF(KF)) u_region (
    .irms_i   (irms_q),
    .irated_i (irated_q),
    .kspd_i   (kspd_q),
    .k1_mode_o(k1_mode_w),
    .k2_div_o (k2_div_w),
    .k1_num_o (num_w[0]),
    .k1_den_o (den_w[0]),
    .k2_num_o (num_w[1]),
    .k2_den_o (den_w[1])
  );

  // lane 0 -> k1 slope, lane 1 -> k2 clamp
  for (genvar g = 0; g < ND; g++) begin : g_div
    sc_gain_div #(.W(DW), .QW(GW)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(start_w),
      .num_i  (num_w[g]),
      .den_i  (den_w[g]),
      .quo_o  (quo_w[g]),
      .done_o (done_w[g])
    );
  end

  always_comb begin
    unique case (k1_mode_w)
      K1_ONE:  k1_raw_w = GAIN_ONE;
      K1_ZERO: k1_raw_w = '0;
      default: k1_raw_w = quo_w[0];
    endcase
  end

  assign k2_new_w = k2_div_w ? quo_w[1] : GAIN_ONE;

  sc_gain_release #(.ALPHA_Q16(ALPHA_Q16)) u_release (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .upd_i (upd_w),
    .raw_i (k1_raw_w),
    .k1_o  (k1_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    k2_q <= GAIN_ONE;
    else if (upd_w) k2_q <= k2_new_w;
  end

  assign k2_o = k2_q;
endmodule

// File: rtl/sc_gain_limiter_chk.sv
module sc_gain_limiter_chk
  import sc_gain_pkg::*;
#(
  parameter int ALPHA_Q16 = 655,
  parameter int LAT       = GW + 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [GW-1:0] k1_o,
  input logic [GW-1:0] k2_o,
  input logic          upd_i
);
  localparam int SCALED  = (int'(GAIN_ONE) * ALPHA_Q16) >>> 16;
  localparam int MAXSTEP = (SCALED < 1) ? 1 : SCALED;

  logic [7:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            gap_q <= '0;
    else if (upd_i)         gap_q <= '0;
    else if (gap_q != 8'hff) gap_q <= gap_q + 1'b1;
  end

  a_r3_k1_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k1_o <= GAIN_ONE);

  a_r5_k2_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k2_o <= GAIN_ONE);

  a_r8_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> ($stable(k1_o) && $stable(k2_o)));

  a_r7_slow_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (k1_o > $past(k1_o)) |-> ((k1_o - $past(k1_o)) <= GW'(MAXSTEP)));

  a_r9_update_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |-> (int'(gap_q) >= LAT));
endmodule

bind sc_gain_limiter sc_gain_limiter_chk #(.ALPHA_Q16(ALPHA_Q16)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .k1_o  (k1_o),
  .k2_o  (k2_o),
  .upd_i (upd_w)
);

// File: tb/sim_sc_gain_limiter.sv
`timescale 1ns/1ps
module sim_sc_gain_limiter;
  localparam int LAT   = 18;
  localparam int ONE   = 32768;
  localparam int ALPHA = 655;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] irms = '0;
  logic [15:0] irated = '0;
  logic [15:0] kspd = '0;
  logic [15:0] k1;
  logic [15:0] k2;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  int exp_k1 = ONE;
  int exp_k2 = ONE;
  int pend_k1 = ONE;
  int pend_k2 = ONE;
  int wait_cnt = 0;

  always #2.5 clk = ~clk;

  sc_gain_limiter u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .tick_i  (tick),
    .irms_i  (irms),
    .irated_i(irated),
    .kspd_i  (kspd),
    .k1_o    (k1),
    .k2_o    (k2)
  );

  task automatic eval_model(input longint ir, input longint ia, input longint kk,
                            input longint prev, output int nk1, output int nk2);
    longint ki, hi, raw, step;
    ki = (kk * ia) >> 12;
    hi = ia + ki;
    if (ir <= ia)      raw = ONE;
    else if (ir >= hi) raw = 0;
    else               raw = ((hi - ir) * ONE) / ki;
    if (ir < ia || ir == 0) nk2 = ONE;
    else                    nk2 = int'((ia * ONE) / ir);
    if (raw > prev) begin
      step = ((raw - prev) * ALPHA) >> 16;
      if (step == 0) step = 1;
      nk1 = int'(prev + step);
    end else begin
      nk1 = int'(raw);
    end
  endtask

  // reference: acceptance rule and fixed latency only
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_k1 = ONE; exp_k2 = ONE; wait_cnt = 0;
    end else if (wait_cnt > 0) begin
      wait_cnt = wait_cnt - 1;
      if (wait_cnt == 0) begin exp_k1 = pend_k1; exp_k2 = pend_k2; end
    end else if (tick) begin
      eval_model(irms, irated, kspd, exp_k1, pend_k1, pend_k2);
      wait_cnt = LAT;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      checks++;
      if (int'(k1) != exp_k1 || int'(k2) != exp_k2) begin
        errors++;
        $display("FAIL %s t=%0t k1 act=%0d exp=%0d k2 act=%0d exp=%0d",
                 cur_req, $time, k1, exp_k1, k2, exp_k2);
      end
    end
  end

  task automatic pulse(input int ir, input int ia, input int kk, input int gap);
    @(negedge clk);
    irms = 16'(ir); irated = 16'(ia); kspd = 16'(kk); tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R1 during reset
    if (k1 !== 16'(ONE) || k2 !== 16'(ONE)) begin
      errors++;
      $display("FAIL R1 reset k1 act=%0d exp=%0d k2 act=%0d exp=%0d", k1, ONE, k2, ONE);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    cur_req = "R2";
    pulse(5000, 8320, 3686, 25);
    pulse(8320, 8320, 3686, 25);
    pulse(0, 0, 3686, 25);
    cur_req = "R3";
    pulse(12000, 8320, 3686, 25);
    pulse(9000, 8320, 3686, 25);
    pulse(15000, 8320, 3686, 25);
    pulse(5000, 1000, 65535, 25);
    cur_req = "R4";
    pulse(15807, 8320, 3686, 25);
    pulse(20000, 8320, 3686, 25);
    pulse(65535, 8320, 3686, 25);
    pulse(8321, 8320, 0, 25);
    cur_req = "R5";
    pulse(8319, 8320, 3686, 25);
    pulse(30000, 0, 3686, 25);
    pulse(40000, 8320, 3686, 25);
    cur_req = "R7";
    pulse(20000, 8320, 3686, 25);
    for (int i = 0; i < 60; i++) pulse(3000, 8320, 3686, 20);
    cur_req = "R6";
    pulse(14000, 8320, 3686, 25);
    pulse(16000, 8320, 3686, 25);
    cur_req = "R7";
    for (int i = 0; i < 5; i++) pulse(12000, 8320, 3686, 19);
    cur_req = "R6";
    pulse(12000, 8320, 3686, 25);
    cur_req = "R9";
    pulse(20000, 8320, 3686, 10);
    pulse(3000, 8320, 3686, 30);
    pulse(20000, 8320, 3686, 18);
    pulse(5000, 8320, 3686, 30);
    pulse(20000, 8320, 3686, 19);
    pulse(5000, 8320, 3686, 30);
    cur_req = "R8";
    for (int i = 0; i < 150; i++)
      pulse(int'($urandom_range(0, 24000)), 8320, int'($urandom_range(0, 8191)),
            int'($urandom_range(8, 40)));
    repeat (30) @(negedge clk);
    finish_run();
  end
endmodule